// File: doc/BRIEF.md
# Masked interrupt event controller

This block keeps the interrupt event flags of a network controller and turns them into thirteen separate interrupt request lines. The transmit and receive engines report events with one-cycle pulses. Each pulse sets a sticky bit in a 32-bit event register. Software reads that register through a small register port and clears bits by writing ones to them. A 32-bit mask register selects which events may reach the request lines. Each line is registered and carries exactly one masked event bit, and the lines follow a fixed order that differs from the bit order of the register.

The same port also reaches three more registers. The controller control register holds an enable bit and a self-clearing reset bit; the reset clears the interrupt state. A transmit control register raises the graceful-stop-complete event as soon as its stop request bit is written. A receive arm register records whether reception has been started. Reads are combinational from the address. Offsets that do not decode read zero.

Top module: `evt_irq_top`

## Requirements
- R1: Pulse input `evtPulse[i]` sets event bit 19+i at the next rising clock edge. The bits are: 31 heartbeat, 30 babbling receive, 29 babbling transmit, 28 graceful stop complete, 27 TX frame, 26 TX buffer, 25 RX frame, 24 RX buffer, 23 MII, 22 bus error, 21 late collision, 20 retry limit, 19 underrun. Event bits 18..0 always read zero.
- R2: A write to the event register (offset 0x00) clears each event bit whose written data bit is 1 and leaves every other bit unchanged.
- R3: When a set pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R4: A write to the mask register (offset 0x04) replaces all 32 bits, and a read returns them. An event is active only while its event bit and its mask bit are both 1.
- R5: `irqLine[0..12]` carry the active state of event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30, in that order.
- R6: `irqLine` is registered. It changes one clock edge after the event or mask register changes.
- R7: A write to the transmit control register (offset 0x0C) stores the value, and a read returns it. If data bit 0 of that write is 1, event bit 28 is set at the same edge.
- R8: In the control register (offset 0x08), bit 1 is enable and bit 0 is reset. A write with bit 0 set clears the event register, the mask register, the receive-active state and the control register. This takes priority over event pulses in the same cycle.
- R9: A write to the receive arm register (offset 0x10) sets the receive-active state only while the enable bit is 1. Reading offset 0x10 returns that state in bit 0. A control write with bit 1 equal to 0 clears the state.
- R10: `regRdData` is a combinational function of `regAddr`. Offsets other than 0x00, 0x04, 0x08, 0x0C and 0x10 read zero.
- R11: After `rstN` is asserted, every register, the receive-active state and all lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the register port, one cycle per write |
| regAddr | input | 8 | Byte offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| evtPulse | input | 13 | Event set pulses; bit i sets event bit 19+i |
| irqLine | output | 13 | Registered masked interrupt request lines |

## Verification
The checker assumes that every input is driven synchronously and holds known values during each clock edge. It also assumes that a write occupies exactly one cycle. The write-one-to-clear property applies only to cycles with no event pulse; the set-wins property covers the mixed case. The bench therefore changes inputs shortly after each rising edge and drops the write strobe after one cycle. It drives pulses and clears either alone or together in a single deliberate cycle. It never combines a control reset with a check that expects surviving events.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_LINES = 13;
  localparam int EVT_LSB   = 19;
  localparam int EVT_W     = DATA_W - EVT_LSB;

  localparam logic [ADDR_W-1:0] OFS_EVENT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_TXCTL = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_RXARM = ADDR_W'(8'h10);

  localparam int CTRL_RST_BIT  = 0;
  localparam int CTRL_EN_BIT   = 1;
  localparam int TXCTL_GTS_BIT = 0;

  localparam int BIT_HEARTBEAT = 31;
  localparam int BIT_BABBLE_RX = 30;
  localparam int BIT_BABBLE_TX = 29;
  localparam int BIT_GRACEFUL  = 28;
  localparam int BIT_TX_FRAME  = 27;
  localparam int BIT_TX_BUF    = 26;
  localparam int BIT_RX_FRAME  = 25;
  localparam int BIT_RX_BUF    = 24;
  localparam int BIT_MII       = 23;
  localparam int BIT_BUS_ERR   = 22;
  localparam int BIT_LATE_COL  = 21;
  localparam int BIT_RETRY_LIM = 20;
  localparam int BIT_UNDERRUN  = 19;

  localparam logic [DATA_W-1:0] IMPL_MASK = {{EVT_W{1'b1}}, {EVT_LSB{1'b0}}};

  typedef enum logic [2:0] {
    RD_NONE, RD_EVENT, RD_MASK, RD_CTRL, RD_TXCTL, RD_RXARM
  } rdSel_t;

  typedef struct packed {
    logic   evtClr;
    logic   maskWr;
    logic   ctrlWr;
    logic   txCtlWr;
    logic   rxArm;
    rdSel_t rdSel;
  } strobe_t;

  // Event bit that drives each request line.
  function automatic int lineBit(int k);
    case (k)
      0:       return BIT_TX_FRAME;
      1:       return BIT_TX_BUF;
      2:       return BIT_UNDERRUN;
      3:       return BIT_RETRY_LIM;
      4:       return BIT_RX_FRAME;
      5:       return BIT_RX_BUF;
      6:       return BIT_MII;
      7:       return BIT_LATE_COL;
      8:       return BIT_HEARTBEAT;
      9:       return BIT_GRACEFUL;
      10:      return BIT_BUS_ERR;
      11:      return BIT_BABBLE_TX;
      default: return BIT_BABBLE_RX;
    endcase
  endfunction
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    case (regAddr)
      OFS_EVENT: begin strb.evtClr  = regWrEn; strb.rdSel = RD_EVENT; end
      OFS_MASK:  begin strb.maskWr  = regWrEn; strb.rdSel = RD_MASK;  end
      OFS_CTRL:  begin strb.ctrlWr  = regWrEn; strb.rdSel = RD_CTRL;  end
      OFS_TXCTL: begin strb.txCtlWr = regWrEn; strb.rdSel = RD_TXCTL; end
      OFS_RXARM: begin strb.rxArm   = regWrEn; strb.rdSel = RD_RXARM; end
      default:   strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [EVT_W-1:0]     evtPulse,
  output logic [DATA_W-1:0]    regRdData,
  output logic [NUM_LINES-1:0] irqLine,
  output logic [DATA_W-1:0]    evtQ,
  output logic [DATA_W-1:0]    maskQ,
  output logic                 rxActive
);
  logic [DATA_W-1:0]    ctrlQ;
  logic [DATA_W-1:0]    txCtlQ;
  logic [DATA_W-1:0]    setVec;
  logic [DATA_W-1:0]    clrVec;
  logic [DATA_W-1:0]    evtNext;
  logic [DATA_W-1:0]    activeVec;
  logic [NUM_LINES-1:0] irqNext;
  logic                 ctrlReset;

  assign ctrlReset = strb.ctrlWr & regWrData[CTRL_RST_BIT];

  always_comb begin
    setVec = {evtPulse, {EVT_LSB{1'b0}}};
    if (strb.txCtlWr && regWrData[TXCTL_GTS_BIT])
      setVec[BIT_GRACEFUL] = 1'b1;
    clrVec  = strb.evtClr ? regWrData : '0;
    // Set wins over a same-cycle clear.
    evtNext = ((evtQ & ~clrVec) | setVec) & IMPL_MASK;
    if (ctrlReset)
      evtNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ     <= '0;
      maskQ    <= '0;
      ctrlQ    <= '0;
      txCtlQ   <= '0;
      rxActive <= 1'b0;
    end else begin
      evtQ <= evtNext;
      if (ctrlReset)
        maskQ <= '0;
      else if (strb.maskWr)
        maskQ <= regWrData;
      if (strb.ctrlWr)
        ctrlQ <= ctrlReset ? '0 : regWrData;
      if (strb.txCtlWr)
        txCtlQ <= regWrData;
      if (strb.ctrlWr && (ctrlReset || !regWrData[CTRL_EN_BIT]))
        rxActive <= 1'b0;
      else if (strb.rxArm && ctrlQ[CTRL_EN_BIT])
        rxActive <= 1'b1;
    end
  end

  assign activeVec = evtQ & maskQ;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_route
    localparam int SRC = lineBit(k);
    assign irqNext[k] = activeVec[SRC];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLine <= '0;
    else       irqLine <= irqNext;
  end

  always_comb begin
    case (strb.rdSel)
      RD_EVENT: regRdData = evtQ;
      RD_MASK:  regRdData = maskQ;
      RD_CTRL:  regRdData = ctrlQ;
      RD_TXCTL: regRdData = txCtlQ;
      RD_RXARM: regRdData = DATA_W'(rxActive);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [EVT_W-1:0]     evtPulse,
  output logic [NUM_LINES-1:0] irqLine
);
  strobe_t           strb;
  logic [DATA_W-1:0] evtQ;
  logic [DATA_W-1:0] maskQ;
  logic              rxActive;

  evt_irq_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  evt_irq_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .evtPulse  (evtPulse),
    .regRdData (regRdData),
    .irqLine   (irqLine),
    .evtQ      (evtQ),
    .maskQ     (maskQ),
    .rxActive  (rxActive)
  );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [EVT_W-1:0]     evtPulse,
  input logic [NUM_LINES-1:0] irqLine,
  input logic [DATA_W-1:0]    evtQ,
  input logic [DATA_W-1:0]    maskQ,
  input logic                 rxActive
);
  logic wrEvent, wrMask, wrRst;
  logic [NUM_LINES-1:0] expLines;

  assign wrEvent = regWrEn && (regAddr == OFS_EVENT);
  assign wrMask  = regWrEn && (regAddr == OFS_MASK);
  assign wrRst   = regWrEn && (regAddr == OFS_CTRL) && regWrData[CTRL_RST_BIT];

  always_comb begin
    expLines = '0;
    for (int k = 0; k < NUM_LINES; k++)
      expLines[k] = evtQ[lineBit(k)] & maskQ[lineBit(k)];
  end

  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    evtQ[EVT_LSB-1:0] == '0);

  a_r2_clear_ones: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvent && evtPulse == '0) |=> evtQ == ($past(evtQ) & ~$past(regWrData)));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0 && !wrRst) |=> ((evtQ[DATA_W-1:EVT_LSB] & $past(evtPulse)) == $past(evtPulse)));

  a_r4_mask_replace: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask && !wrRst) |=> maskQ == $past(regWrData));

  a_r6_line_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqLine == $past(expLines));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrRst |=> (evtQ == '0 && maskQ == '0 && !rxActive));
endmodule

bind evt_irq_top evt_irq_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtPulse  (evtPulse),
  .irqLine   (irqLine),
  .evtQ      (evtQ),
  .maskQ     (maskQ),
  .rxActive  (rxActive)
);

// File: tb/evt_irq_top_tb_top.sv
`timescale 1ns/1ps
module evt_irq_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [12:0] evtPulse = '0;
  logic [12:0] irqLine;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  int lineSrc[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #2.5 clk = ~clk;

  evt_irq_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .irqLine(irqLine)
  );

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.isIrq ? {19'b0, irqLine} : regRdData;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [12:0] p);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d; evtPulse = p;
    @(posedge clk); #1;
    regWrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic pls(input logic [12:0] p);
    @(posedge clk); #1;
    evtPulse = p;
    @(posedge clk); #1;
    evtPulse = '0;
  endtask

  task automatic chkRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    regAddr = a;
    it.isIrq = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chkIrqNow(input logic [12:0] e, input string tag);
    item_t it;
    it.isIrq = 1; it.exp = {19'b0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic chkIrq(input logic [12:0] e, input string tag);
    @(posedge clk); #1;
    chkIrqNow(e, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11 reset state
    chkRd(8'h00, 32'h0, "R11 event after reset");
    chkRd(8'h04, 32'h0, "R11 mask after reset");
    chkRd(8'h08, 32'h0, "R11 ctrl after reset");
    chkRd(8'h10, 32'h0, "R11 rx after reset");
    chkIrq(13'h0, "R11 lines after reset");
    // R1 pulse sets TX frame bit 27
    pls(13'h1 << (27 - 19));
    chkRd(8'h00, 32'h0800_0000, "R1 tx frame bit");
    chkIrq(13'h0, "R4 masked line stays low");
    // R4 mask
    wr(8'h04, 32'hFFFF_FFFF, 13'h0);
    chkRd(8'h04, 32'hFFFF_FFFF, "R4 mask readback");
    chkIrq(13'h001, "R5 tx frame on line0");
    // R6 latency
    pls(13'h1 << (31 - 19));
    chkIrqNow(13'h001, "R6 line not yet updated");
    chkIrq(13'h101, "R6 heartbeat on line8 next edge");
    // R2 clear
    wr(8'h00, 32'h0800_0000, 13'h0);
    chkRd(8'h00, 32'h8000_0000, "R2 clear tx frame");
    chkIrq(13'h100, "R2 line0 dropped");
    pls(13'h1FFF);
    chkRd(8'h00, 32'hFFF8_0000, "R1 all pulses, low bits zero");
    wr(8'h00, 32'h5555_5555, 13'h0);
    chkRd(8'h00, 32'hAAA8_0000, "R2 mixed clear");
    // R3 set wins over clear
    wr(8'h00, 32'h0030_0000, 13'h1 << (20 - 19));
    chkRd(8'h00, 32'hAA98_0000, "R3 set wins");
    // R4 partial mask
    wr(8'h04, 32'h0810_0000, 13'h0);
    chkRd(8'h04, 32'h0810_0000, "R4 partial mask readback");
    chkIrq(13'h009, "R5 lines 0 and 3");
    // R7 tx control
    wr(8'h0C, 32'h0000_0001, 13'h0);
    chkRd(8'h0C, 32'h0000_0001, "R7 txctl readback");
    chkRd(8'h00, 32'hBA98_0000, "R7 graceful bit 28");
    // R9 rx arm
    wr(8'h10, 32'h1, 13'h0);
    chkRd(8'h10, 32'h0, "R9 arm ignored while disabled");
    wr(8'h08, 32'h2, 13'h0);
    chkRd(8'h08, 32'h2, "R8 ctrl enable readback");
    wr(8'h10, 32'h1, 13'h0);
    chkRd(8'h10, 32'h1, "R9 arm while enabled");
    wr(8'h08, 32'h0, 13'h0);
    chkRd(8'h10, 32'h0, "R9 disable clears rx");
    // R8 reset beats pulse
    wr(8'h08, 32'h2, 13'h0);
    wr(8'h10, 32'h1, 13'h0);
    wr(8'h08, 32'h3, 13'h1FFF);
    chkRd(8'h00, 32'h0, "R8 events cleared");
    chkRd(8'h04, 32'h0, "R8 mask cleared");
    chkRd(8'h10, 32'h0, "R8 rx cleared");
    chkRd(8'h08, 32'h0, "R8 ctrl reads zero");
    chkIrq(13'h0, "R8 lines low");
    // R10 unimplemented offsets
    chkRd(8'h14, 32'h0, "R10 offset 0x14");
    chkRd(8'h20, 32'h0, "R10 offset 0x20");
    chkRd(8'h02, 32'h0, "R10 offset 0x02");
    // R5 full routing sweep
    wr(8'h04, 32'hFFFF_FFFF, 13'h0);
    for (int k = 0; k < 13; k++) begin
      pls(13'h1 << (lineSrc[k] - 19));
      chkIrq(13'h1 << k, $sformatf("R5 route line %0d", k));
      wr(8'h00, 32'hFFFF_FFFF, 13'h0);
    end
    chkIrq(13'h0, "R2 all cleared lines low");
    @(posedge clk); @(negedge clk); #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule